// File: doc/BRIEF.md
# Branch Record Filter with Banked Readout

This block sits beside the retirement stage of a processor core and decides, for every retired branch, whether a record of that branch goes into a 64-entry circular record store. Each retired branch arrives as a valid strobe with a one-hot type code and its source and target addresses. A 64-bit control word sets the decision. Six per-type match enables say which branch types count as matches. A polarity bit picks between recording matches and recording everything else. A pause bit stops all recording.

The control word also holds a sticky transaction-failure flag and a 2-bit bank field. The flag is set by a failure or cancellation pulse and is cleared when the next record is written. The bank field maps one 32-entry window of the store onto a read port that is addressed with a 5-bit index. Software loads the control word through a simple write strobe and reads it back in full. A clear input empties the store. Recording is not gated on privilege, and no timestamps are kept.

Top module: `brec_filter_top`

## Requirements
- R1: The branch type code is one-hot: bit 5 conditional direct, bit 4 direct call, bit 3 indirect call, bit 2 return, bit 1 indirect, bit 0 unconditional direct. Control bits 22 down to 17 enable matching for type bits 5 down to 0 respectively. A branch matches when the enable of its type is set.
- R2: Control bit 16 is the polarity. When it is 0, a valid branch is recorded only if it matches. When it is 1, a valid branch is recorded only if it does not match.
- R3: While control bit 7 (pause) is 1, no record is written, whatever the enables and polarity.
- R4: Control bits 29:28 form the bank field. Bank 0 shows entries 0 to 31 and bank 1 shows entries 32 to 63, so the read port shows entry bank*32 + index.
- R5: Control bit 6 is the failure flag. A failure pulse sets it. The first record written after that clears it. A branch that is not recorded leaves it unchanged. If a pulse and a record write fall in the same cycle, the flag is set at the end of that cycle. A control write loads the flag from write-data bit 6 unless a pulse arrives in the same cycle.
- R6: Only control bits 29:28, 22:16, 7 and 6 are writable. All other bits read as zero, so writing all ones reads back as 0x00000000307F00C0.
- R7: Records are written at a 6-bit write pointer that starts at entry 0 and wraps from 63 back to 0. Each record holds the source, the target, the 6-bit type code and a valid bit. A record can be read from the cycle after its branch.
- R8: When the bank field holds 2 or 3, the read port returns zero source, target and type, drives valid low, and drives the bad-bank flag high.
- R9: A clear input invalidates every entry and returns the write pointer to entry 0. A record decision in the same cycle as a clear is dropped.
- R10: After reset the control word reads zero and every entry reads invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| br_valid | input | 1 | A branch retired this cycle |
| br_type | input | 6 | One-hot branch type code |
| br_src | input | ADDR_W | Branch source address |
| br_tgt | input | ADDR_W | Branch target address |
| txn_fail | input | 1 | Transaction failure or cancellation pulse |
| rec_clear | input | 1 | Invalidate all records and reset the write pointer |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 64 | Control word write data |
| cfg_rdata | output | 64 | Control word read data |
| rd_idx | input | IDX_W | Record index within the selected bank |
| rd_valid | output | 1 | Selected record is valid |
| rd_src | output | ADDR_W | Selected record source address |
| rd_tgt | output | ADDR_W | Selected record target address |
| rd_type | output | 6 | Selected record type code |
| rd_bad_bank | output | 1 | Bank field holds a reserved value |

## Verification
The assertions check the following on every cycle:
- the pause gate never lets a record through;
- the type code is one-hot whenever a branch is valid;
- the write pointer steps by exactly one per record and holds otherwise;
- a clear leaves every entry invalid;
- a reserved bank gives a zero, invalid readout;
- the failure flag is set after a pulse and cleared after a record.

Only the bench scenarios can show the rest:
- that the filter picks the right branches for all 64 enable patterns under both polarities and with pause set;
- that the records sit at the expected entries after the pointer wraps;
- that the two bank windows map onto the right halves of the store;
- how the flag behaves when a pulse and a record meet in one cycle.

// File: rtl/brec_pkg.sv
package brec_pkg;
    localparam int CTL_W     = 64;
    localparam int NTYPE     = 6;
    localparam int BANK_LO   = 28;
    localparam int EN_LO     = 17;
    localparam int POL_BIT   = 16;
    localparam int PAUSE_BIT = 7;
    localparam int FAIL_BIT  = 6;

    // Writable bits other than the failure flag, which has its own update rule.
    localparam logic [CTL_W-1:0] CFG_WR_MASK = 64'h0000_0000_307F_0080;

    typedef struct packed {
        logic [1:0]       bank;
        logic [NTYPE-1:0] en;
        logic             pol;
        logic             paused;
    } brec_ctl_t;
endpackage

// File: rtl/brec_ctrl.sv
module brec_ctrl
    import brec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [CTL_W-1:0] cfg_wdata,
    input  logic             txn_fail,
    input  logic             rec_fire,
    output brec_ctl_t        ctl,
    output logic [CTL_W-1:0] cfg_rdata
);
    logic [CTL_W-1:0] ctl_q;
    logic             fail_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (cfg_wr_en) begin
            ctl_q <= cfg_wdata & CFG_WR_MASK;
        end
    end

    // Failure flag: a pulse wins, then a software write, then a record clears it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
        end else if (txn_fail) begin
            fail_q <= 1'b1;
        end else if (cfg_wr_en) begin
            fail_q <= cfg_wdata[FAIL_BIT];
        end else if (rec_fire) begin
            fail_q <= 1'b0;
        end
    end

    always_comb begin
        ctl.bank   = ctl_q[BANK_LO +: 2];
        ctl.en     = ctl_q[EN_LO +: NTYPE];
        ctl.pol    = ctl_q[POL_BIT];
        ctl.paused = ctl_q[PAUSE_BIT];
        cfg_rdata  = ctl_q | (CTL_W'(fail_q) << FAIL_BIT);
    end

    AST_FAIL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        txn_fail |=> cfg_rdata[FAIL_BIT]); // R5
    AST_FAIL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_fire && !txn_fail && !cfg_wr_en) |=> !cfg_rdata[FAIL_BIT]); // R5
    AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rec_fire && !txn_fail && !cfg_wr_en) |=> $stable(cfg_rdata[FAIL_BIT])); // R5
endmodule

// File: rtl/brec_match.sv
module brec_match
    import brec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    input  logic [NTYPE-1:0] br_type,
    input  brec_ctl_t        ctl,
    input  logic             rec_clear,
    output logic             rec_fire
);
    logic type_hit;

    always_comb begin
        type_hit = |(br_type & ctl.en);
        rec_fire = br_valid && !ctl.paused && !rec_clear && (type_hit ^ ctl.pol);
    end

    AST_TYPE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |-> ($countones(br_type) == 1)); // R1
endmodule

// File: rtl/brec_store.sv
module brec_store
    import brec_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DEPTH   = 64,
    parameter int BANK_SZ = 32,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int IDX_W  = $clog2(BANK_SZ),
    localparam int NBANK  = DEPTH / BANK_SZ
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_src,
    input  logic [ADDR_W-1:0] wr_tgt,
    input  logic [NTYPE-1:0]  wr_type,
    input  logic              clear,
    input  logic [1:0]        bank,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_src,
    output logic [ADDR_W-1:0] rd_tgt,
    output logic [NTYPE-1:0]  rd_type,
    output logic              rd_bad
);
    logic [ADDR_W-1:0] src_q  [DEPTH];
    logic [ADDR_W-1:0] tgt_q  [DEPTH];
    logic [NTYPE-1:0]  type_q [DEPTH];
    logic [DEPTH-1:0]  valid_q;
    logic [PTR_W-1:0]  wptr;
    logic [PTR_W-1:0]  rd_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr    <= '0;
            valid_q <= '0;
        end else if (clear) begin
            wptr    <= '0;
            valid_q <= '0;
        end else if (wr_en) begin
            wptr          <= wptr + 1'b1;
            valid_q[wptr] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clear) begin
            src_q[wptr]  <= wr_src;
            tgt_q[wptr]  <= wr_tgt;
            type_q[wptr] <= wr_type;
        end
    end

    always_comb begin
        rd_bad = (int'(bank) >= NBANK);
        rd_ptr = PTR_W'(bank) * PTR_W'(BANK_SZ) + PTR_W'(rd_idx);
        if (rd_bad) begin
            rd_valid = 1'b0;
            rd_src   = '0;
            rd_tgt   = '0;
            rd_type  = '0;
        end else begin
            rd_valid = valid_q[rd_ptr];
            rd_src   = src_q[rd_ptr];
            rd_tgt   = tgt_q[rd_ptr];
            rd_type  = type_q[rd_ptr];
        end
    end

    AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |=> (wptr == PTR_W'($past(wptr) + 1'b1))); // R7
    AST_WPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clear) |=> $stable(wptr)); // R7
    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (valid_q == '0 && wptr == '0)); // R9
    AST_BAD_BANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bad |-> (!rd_valid && rd_src == '0 && rd_tgt == '0 && rd_type == '0)); // R8
endmodule

// File: rtl/brec_filter_top.sv
module brec_filter_top
    import brec_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DEPTH   = 64,
    parameter int BANK_SZ = 32,
    localparam int IDX_W  = $clog2(BANK_SZ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [5:0]        br_type,
    input  logic [ADDR_W-1:0] br_src,
    input  logic [ADDR_W-1:0] br_tgt,
    input  logic              txn_fail,
    input  logic              rec_clear,
    input  logic              cfg_wr_en,
    input  logic [63:0]       cfg_wdata,
    output logic [63:0]       cfg_rdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_src,
    output logic [ADDR_W-1:0] rd_tgt,
    output logic [5:0]        rd_type,
    output logic              rd_bad_bank
);
    brec_ctl_t ctl;
    logic      rec_fire;

    brec_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_en (cfg_wr_en),
        .cfg_wdata (cfg_wdata),
        .txn_fail  (txn_fail),
        .rec_fire  (rec_fire),
        .ctl       (ctl),
        .cfg_rdata (cfg_rdata)
    );

    brec_match u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .br_valid  (br_valid),
        .br_type   (br_type),
        .ctl       (ctl),
        .rec_clear (rec_clear),
        .rec_fire  (rec_fire)
    );

    brec_store #(
        .ADDR_W  (ADDR_W),
        .DEPTH   (DEPTH),
        .BANK_SZ (BANK_SZ)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rec_fire),
        .wr_src   (br_src),
        .wr_tgt   (br_tgt),
        .wr_type  (br_type),
        .clear    (rec_clear),
        .bank     (ctl.bank),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_src   (rd_src),
        .rd_tgt   (rd_tgt),
        .rd_type  (rd_type),
        .rd_bad   (rd_bad_bank)
    );

    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.paused |-> !rec_fire); // R3
endmodule

// File: tb/tb_brec_filter_top.sv
`timescale 1ns/1ps
module tb_brec_filter_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0;
    logic [5:0]  br_type = '0;
    logic [31:0] br_src = '0;
    logic [31:0] br_tgt = '0;
    logic        txn_fail = 1'b0;
    logic        rec_clear = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [63:0] cfg_wdata = '0;
    logic [63:0] cfg_rdata;
    logic [4:0]  rd_idx = '0;
    logic        rd_valid;
    logic [31:0] rd_src;
    logic [31:0] rd_tgt;
    logic [5:0]  rd_type;
    logic        rd_bad_bank;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    brec_filter_top dut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_type(br_type),
        .br_src(br_src), .br_tgt(br_tgt), .txn_fail(txn_fail),
        .rec_clear(rec_clear), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .rd_idx(rd_idx), .rd_valid(rd_valid),
        .rd_src(rd_src), .rd_tgt(rd_tgt), .rd_type(rd_type),
        .rd_bad_bank(rd_bad_bank)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_cfg(logic [1:0] bank, logic [5:0] en,
                                           logic pol, logic pause, logic flag);
        return (64'(bank) << 28) | (64'(en) << 17) | (64'(pol) << 16)
             | (64'(pause) << 7) | (64'(flag) << 6);
    endfunction

    task automatic write_cfg(logic [63:0] v);
        cfg_wdata = v;
        cfg_wr_en = 1'b1;
        tick();
        cfg_wr_en = 1'b0;
    endtask

    task automatic do_clear();
        rec_clear = 1'b1;
        tick();
        rec_clear = 1'b0;
    endtask

    task automatic branch(int t, logic [31:0] s, logic [31:0] d);
        br_valid = 1'b1;
        br_type  = 6'(1 << t);
        br_src   = s;
        br_tgt   = d;
        tick();
        br_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] es [6];
        logic [5:0]  et [6];
        int n;
        repeat (3) tick();
        // R10: reset state
        chk("R10 cfg", cfg_rdata, 64'h0);
        chk("R10 valid", 64'(rd_valid), 64'h0);
        rst_n = 1'b1;
        tick();

        // R1/R2/R3 sweep: every enable pattern, both polarities, pause on/off
        for (int c = 0; c < 256; c++) begin
            logic [5:0] en;
            logic pol, pz;
            en = c[5:0]; pol = c[6]; pz = c[7];
            do_clear();
            write_cfg(mk_cfg(2'd0, en, pol, pz, 1'b0));
            n = 0;
            for (int t = 0; t < 6; t++) begin
                logic [31:0] s, d;
                s = 32'h1000_0000 | (32'(c) << 8) | 32'(t);
                d = 32'h2000_0000 ^ (32'(c) << 12) ^ 32'(t * 3);
                branch(t, s, d);
                if (!pz && (en[t] ^ pol)) begin
                    es[n] = s;
                    et[n] = 6'(1 << t);
                    n++;
                end
            end
            for (int k = 0; k <= 6; k++) begin
                rd_idx = 5'(k);
                #1;
                if (k < n) begin
                    chk("R1/R2 valid", 64'(rd_valid), 64'h1);
                    chk("R7 src", 64'(rd_src), 64'(es[k]));
                    chk("R1 type", 64'(rd_type), 64'(et[k]));
                end else if (k == n) begin
                    chk("R2/R3 no extra record", 64'(rd_valid), 64'h0);
                end
            end
        end

        // R7/R4: wrap past 64 entries, read both bank windows
        do_clear();
        write_cfg(mk_cfg(2'd0, 6'h3F, 1'b0, 1'b0, 1'b0));
        for (int j = 0; j < 70; j++)
            branch(j % 6, 32'hA000_0000 + 32'(j), 32'hB000_0000 + 32'(j));
        for (int b = 0; b < 2; b++) begin
            write_cfg(mk_cfg(2'(b), 6'h3F, 1'b0, 1'b0, 1'b0));
            for (int i = 0; i < 32; i++) begin
                int e, j;
                e = b * 32 + i;
                j = (e < 6) ? e + 64 : e;
                rd_idx = 5'(i);
                #1;
                chk("R4/R7 wrap src", 64'(rd_src), 64'(32'hA000_0000 + 32'(j)));
                chk("R4/R7 wrap tgt", 64'(rd_tgt), 64'(32'hB000_0000 + 32'(j)));
                chk("R7 wrap type", 64'(rd_type), 64'(1 << (j % 6)));
            end
        end

        // R8: reserved bank values
        for (int b = 2; b < 4; b++) begin
            write_cfg(mk_cfg(2'(b), 6'h3F, 1'b0, 1'b0, 1'b0));
            rd_idx = 5'd3;
            #1;
            chk("R8 bad flag", 64'(rd_bad_bank), 64'h1);
            chk("R8 valid", 64'(rd_valid), 64'h0);
            chk("R8 src zero", 64'(rd_src), 64'h0);
            chk("R8 type zero", 64'(rd_type), 64'h0);
        end

        // R5: sticky failure flag
        write_cfg(mk_cfg(2'd0, 6'h00, 1'b0, 1'b0, 1'b0));
        chk("R5 flag idle", 64'(cfg_rdata[6]), 64'h0);
        txn_fail = 1'b1; tick(); txn_fail = 1'b0;
        chk("R5 flag set", 64'(cfg_rdata[6]), 64'h1);
        branch(2, 32'h1, 32'h2);
        chk("R5 unrecorded keeps flag", 64'(cfg_rdata[6]), 64'h1);
        write_cfg(mk_cfg(2'd0, 6'h3F, 1'b0, 1'b0, 1'b1));
        chk("R5 write keeps flag", 64'(cfg_rdata[6]), 64'h1);
        branch(2, 32'h3, 32'h4);
        chk("R5 record clears flag", 64'(cfg_rdata[6]), 64'h0);
        txn_fail = 1'b1;
        branch(0, 32'h5, 32'h6);
        txn_fail = 1'b0;
        chk("R5 same-cycle pulse wins", 64'(cfg_rdata[6]), 64'h1);
        branch(1, 32'h7, 32'h8);
        chk("R5 next record clears", 64'(cfg_rdata[6]), 64'h0);

        // R9: clear precedence and pointer reset
        do_clear();
        branch(3, 32'hC0, 32'hC1);
        rec_clear = 1'b1;
        branch(4, 32'hD0, 32'hD1);
        rec_clear = 1'b0;
        rd_idx = 5'd0;
        #1;
        chk("R9 cleared with record", 64'(rd_valid), 64'h0);
        branch(5, 32'hE0, 32'hE1);
        rd_idx = 5'd0;
        #1;
        chk("R9 pointer back to 0", 64'(rd_src), 64'hE0);
        rd_idx = 5'd1;
        #1;
        chk("R9 dropped record absent", 64'(rd_valid), 64'h0);

        // R6: reserved bits
        write_cfg(64'hFFFF_FFFF_FFFF_FFFF);
        chk("R6 writable mask", cfg_rdata, 64'h0000_0000_307F_00C0);
        write_cfg(64'hCFC0_0000_CF80_FF3F);
        chk("R6 reserved only", cfg_rdata, 64'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule